// File: doc/BRIEF.md
# Segmentable Sparse Dot-Product MAC Chain

This block is a cascade of sixteen signed multiply-accumulate stages that can run either as one long dot product or be cut at runtime into several equal, independent sub-chains. A small mode register gives the number of sub-chains as a power of two (1, 2, 4 or 8). A cut between two stages stops the carried partial sum there and turns the last stage of each piece into a result tap. With a single sub-chain the block computes a dense dot product of the sixteen weights with the sixteen activations in order. With more than one sub-chain it serves N:M structured sparsity. Each stage then fetches its activation through a 4-bit index from a sixteen-entry activation register file, and reads its weight from its own fixed slot.

An operation is one beat that carries all sixteen weights and sixteen indices. The block samples its activations and weights on that beat, lets the partial sums ripple through the stages one register per stage, and then emits one result per sub-chain. Results leave in ascending lane order on consecutive cycles, each tagged with its lane number. A per-lane gate mask switches whole sub-chains off for block sparsity. A gated sub-chain does no multiply-accumulate work, but its zero result is still emitted, so every operation yields exactly N results. Software decides when to fall back to dense mode for weakly sparse data. It changes the mode and gate mask only while the block is idle.

Top module: `sparse_dot_chain`

## Requirements
- R1: With `cfg_lanes_log2` = 0 (one lane), an operation yields a single result on lane 0 equal to the sum over s = 0..15 of act[s]·w[s]. The index inputs are not used, and weight s is taken from `op_w[8s+7:8s]` as a signed byte.
- R2: With `cfg_lanes_log2` = k (1 to 3), N = 2^k lanes of length L = 16/N are formed. Lane c equals the sum over j = 0..L-1 of act[idx[s]]·w[s] with s = c·L + j. The index idx[s] is `op_idx[4s+3:4s]`.
- R3: Every accepted operation produces exactly N beats of `out_valid`, on consecutive cycles, with `out_lane` running 0, 1, …, N-1.
- R4: The first result beat is visible in the cycle that follows the (L+1)-th rising edge after the edge that accepts the operation.
- R5: When bit c of `cfg_gate` is 1 and c < N, lane c reports 0 and is still emitted. Gate bits for lanes at or above N have no effect.
- R6: While `busy` is 1, `cfg_we` and `op_valid` are ignored. A configuration or operation offered then changes neither the current results nor the lane count of the next operation.
- R7: `act_we` writes `act_data` into activation entry `act_addr`. An operation uses the activations held at its accepting edge. A write made while busy leaves the running operation unchanged and is seen by the next one.
- R8: After reset `busy` and `out_valid` are 0, every activation is 0, the mode is one lane and no lane is gated. `busy` rises at the accepting edge and falls at the edge after the last result beat.
- R9: Products of signed 8-bit operands accumulate in 32 bits without wrap. Sixteen products of -128·-128 give 262144.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write mode and gate mask (taken only when idle) |
| cfg_lanes_log2 | input | 2 | log2 of the lane count: 0 dense, 1..3 sparse |
| cfg_gate | input | 8 | Per-lane gate mask, bit c switches lane c off |
| act_we | input | 1 | Activation register file write enable |
| act_addr | input | 4 | Activation entry to write |
| act_data | input | 8 | Signed activation value |
| op_valid | input | 1 | Start an operation (taken only when idle) |
| op_w | input | 128 | Sixteen signed weights, stage s at bits 8s+7:8s |
| op_idx | input | 64 | Sixteen activation indices, stage s at bits 4s+3:4s |
| busy | output | 1 | An operation is in flight or still emitting |
| out_valid | output | 1 | A result beat is present |
| out_lane | output | 3 | Lane number of the present result |
| out_data | output | 32 | Signed lane result |

## Verification
A wrong cut position or lane decode shows up in the data of the first result beat. A cut one stage early or late moves a product into the neighbouring lane, so two adjacent lane sums are wrong at once, about L+1 cycles after the operation starts. A broken valid ripple or emission counter shows instead as a wrong first-beat cycle, a missing or extra beat, or a lane tag out of sequence, and `busy` stays high or drops early. A gather mux that picks the wrong entry, or that samples the register file too late, shows as a mismatch only on lanes whose indices point at the disturbed entry. For that reason the random stimulus is mixed with writes made while the block is busy.

// File: rtl/sdc_pkg.sv
// Shared helpers for the segmentable dot-product chain.
// Assumes: segment lengths are powers of two and stages are numbered from 0.
package sdc_pkg;

    // Number of bits in the mode field that selects the lane count.
    localparam int unsigned SDC_MODE_W = 2;

    // True when stage s opens a segment of length 2**seg_log2.
    function automatic bit stage_is_head(input int s, input int seg_log2);
        return (s & ((1 << seg_log2) - 1)) == 0;
    endfunction

    // Lane that owns stage s for a segment length of 2**seg_log2.
    function automatic int lane_of_stage(input int s, input int seg_log2);
        return s >> seg_log2;
    endfunction

    // Last stage of lane c for a segment length of 2**seg_log2.
    function automatic int tail_of_lane(input int c, input int seg_log2);
        return ((c + 1) << seg_log2) - 1;
    endfunction

endpackage

// File: rtl/sdc_gather.sv
// Activation register file plus per-stage gather multiplexers.
// Holds M signed activations. On 'capture' every stage latches its operand:
// the activation with its own number in dense mode, or the entry named by
// its index in sparse mode. The captured operands stay constant until the
// next capture. A write on the capture edge is not seen by that capture.
module sdc_gather #(
    parameter int unsigned M  = 16,
    parameter int unsigned DW = 8,
    localparam int unsigned IW = $clog2(M)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              capture,
    input  logic              dense,
    input  logic [M*IW-1:0]   idx_flat,
    output logic [M*DW-1:0]   x_flat
);

    logic [DW-1:0] act_q [M];

    // Activation register file write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(M); i++) act_q[i] <= '0;
        end else if (wr_en) begin
            act_q[wr_addr] <= wr_data;
        end
    end

    for (genvar s = 0; s < int'(M); s++) begin : g_pick
        logic [IW-1:0] sel;

        // Operand source: own entry when dense, indexed entry when sparse.
        always_comb sel = dense ? IW'(s) : idx_flat[s*IW +: IW];

        // Latch the gathered operand at the start of an operation.
        always_ff @(posedge clk) begin
            if (!rst_n)       x_flat[s*DW +: DW] <= '0;
            else if (capture) x_flat[s*DW +: DW] <= act_q[sel];
        end
    end

endmodule

// File: rtl/sdc_mac_stage.sv
// One multiply-accumulate stage of the cascade.
// A head stage starts from zero when the start pulse arrives. Any other stage
// adds its product to the carried sum once its neighbour's valid is seen.
// A gated stage keeps its cleared sum and does no work. The valid bit still
// ripples through it so that all lanes finish on the same cycle.
module sdc_mac_stage #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 32,
    localparam int unsigned PW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          go,
    input  logic          prev_vld,
    input  logic          head,
    input  logic          gate,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] w,
    input  logic [AW-1:0] acc_in,
    output logic          vld,
    output logic [AW-1:0] acc
);

    logic          step;
    logic [PW-1:0] prod;
    logic [AW-1:0] prod_ext;
    logic [AW-1:0] base;

    // Signed product, sign-extended to the accumulator width.
    always_comb begin
        prod     = PW'($signed(x) * $signed(w));
        prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
    end

    // Reduction node: a head stage breaks the carry and starts at zero.
    always_comb begin
        base = head ? '0 : acc_in;
        step = (head ? go : prev_vld) && !gate;
    end

    // Valid ripple, one register per stage.
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= head ? go : prev_vld;
    end

    // Running sum: cleared at operation start, updated once per operation.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (clr)  acc <= '0;
        else if (step) acc <= base + prod_ext;
    end

endmodule

// File: rtl/sdc_emit.sv
// Result queue and serializer.
// On 'capture' it stores every lane result in one cycle. It then presents
// them one per cycle in ascending lane order and flags the last beat with
// 'done'. Assumes no new capture arrives while results are still pending.
module sdc_emit #(
    parameter int unsigned AW   = 32,
    parameter int unsigned MAXN = 8,
    parameter int unsigned MW   = 2,
    localparam int unsigned LW  = $clog2(MAXN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [MW-1:0]    lanes_log2,
    input  logic [MAXN*AW-1:0] tail_flat,
    output logic             out_valid,
    output logic [LW-1:0]    out_lane,
    output logic [AW-1:0]    out_data,
    output logic             done
);

    logic [AW-1:0] bank [MAXN];
    logic [LW-1:0] cnt;
    logic          pending;
    logic [LW:0]   n_lanes;
    logic          last;

    // Last lane number for the present mode.
    always_comb begin
        n_lanes = (LW+1)'(1) << lanes_log2;
        last    = ({1'b0, cnt} == n_lanes - (LW+1)'(1));
    end

    for (genvar c = 0; c < int'(MAXN); c++) begin : g_bank
        // Hold one lane result from capture until it is sent.
        always_ff @(posedge clk) begin
            if (!rst_n)       bank[c] <= '0;
            else if (capture) bank[c] <= tail_flat[c*AW +: AW];
        end
    end

    // Emission counter walking lanes 0..N-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else if (capture) begin
            pending <= 1'b1;
            cnt     <= '0;
        end else if (pending) begin
            pending <= !last;
            cnt     <= last ? '0 : cnt + LW'(1);
        end
    end

    // Present the current beat.
    always_comb begin
        out_valid = pending;
        out_lane  = cnt;
        out_data  = bank[cnt];
        done      = pending && last;
    end

endmodule

// File: rtl/sparse_dot_chain.sv
// Segmentable sparse dot-product MAC chain (top).
// M cascaded MAC stages, cut at runtime into 2**mode lanes of equal length.
// One op_valid beat starts an operation: operands are gathered and latched,
// the sums ripple one stage per cycle, and the lane results are then emitted
// in ascending order. Mode and gate mask are taken only while idle.
// Assumes M is a power of two and 2**MAX_LOG2N <= M/2.
module sparse_dot_chain #(
    parameter int unsigned M         = 16,
    parameter int unsigned DW        = 8,
    parameter int unsigned AW        = 32,
    parameter int unsigned MAX_LOG2N = 3,
    localparam int unsigned IW   = $clog2(M),
    localparam int unsigned MAXN = 1 << MAX_LOG2N,
    localparam int unsigned LW   = $clog2(MAXN),
    localparam int unsigned MW   = sdc_pkg::SDC_MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MW-1:0]     cfg_lanes_log2,
    input  logic [MAXN-1:0]   cfg_gate,
    input  logic              act_we,
    input  logic [IW-1:0]     act_addr,
    input  logic [DW-1:0]     act_data,
    input  logic              op_valid,
    input  logic [M*DW-1:0]   op_w,
    input  logic [M*IW-1:0]   op_idx,
    output logic              busy,
    output logic              out_valid,
    output logic [LW-1:0]     out_lane,
    output logic [AW-1:0]     out_data
);
    import sdc_pkg::*;

    localparam int unsigned LOG2M = $clog2(M);
    localparam int unsigned SLW   = $clog2(LOG2M + 1);

    logic              busy_q;
    logic              go_q;
    logic [MW-1:0]     mode_q;
    logic [MAXN-1:0]   gate_q;
    logic [M*DW-1:0]   w_q;
    logic [M*DW-1:0]   x_flat;
    logic              accept;
    logic              emit_done;
    logic [SLW-1:0]    seg_log2;
    logic              vld [M];
    logic [AW-1:0]     acc [M];
    logic [MAXN*AW-1:0] tail_flat;

    // Operation accepted only when idle.
    always_comb accept = op_valid && !busy_q;

    // Segment length as a power of two: M / 2**mode.
    always_comb seg_log2 = SLW'(LOG2M) - SLW'(mode_q);

    // Mode and gate mask, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            gate_q <= '0;
        end else if (cfg_we && !busy_q) begin
            mode_q <= cfg_lanes_log2;
            gate_q <= cfg_gate;
        end
    end

    // Busy flag from acceptance until the last result beat.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (accept)    busy_q <= 1'b1;
        else if (emit_done) busy_q <= 1'b0;
    end

    // Start pulse for the segment heads, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= accept;
    end

    // Weight latch, held for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n)      w_q <= '0;
        else if (accept) w_q <= op_w;
    end

    sdc_gather #(.M(M), .DW(DW)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (act_we),
        .wr_addr  (act_addr),
        .wr_data  (act_data),
        .capture  (accept),
        .dense    (mode_q == '0),
        .idx_flat (op_idx),
        .x_flat   (x_flat)
    );

    for (genvar s = 0; s < int'(M); s++) begin : g_stage
        logic          head;
        logic          gate;
        logic          prev_vld;
        logic [AW-1:0] acc_in;

        // Cut position and lane gate for this stage in the present mode.
        always_comb begin
            head = stage_is_head(s, int'(seg_log2));
            gate = gate_q[LW'(lane_of_stage(s, int'(seg_log2)))];
        end

        if (s == 0) begin : g_first
            // First stage has no upstream neighbour.
            always_comb begin
                prev_vld = 1'b0;
                acc_in   = '0;
            end
        end else begin : g_next
            // Cascade carry from the previous stage.
            always_comb begin
                prev_vld = vld[s-1];
                acc_in   = acc[s-1];
            end
        end

        sdc_mac_stage #(.DW(DW), .AW(AW)) u_mac (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (accept),
            .go       (go_q),
            .prev_vld (prev_vld),
            .head     (head),
            .gate     (gate),
            .x        (x_flat[s*DW +: DW]),
            .w        (w_q[s*DW +: DW]),
            .acc_in   (acc_in),
            .vld      (vld[s]),
            .acc      (acc[s])
        );
    end

    // Collect the tail sum of each active lane; unused lanes read zero.
    always_comb begin
        for (int c = 0; c < int'(MAXN); c++) begin
            logic [IW-1:0] tix;
            tix = IW'(tail_of_lane(c, int'(seg_log2)));
            if (c < (1 << mode_q)) tail_flat[c*AW +: AW] = acc[tix];
            else                   tail_flat[c*AW +: AW] = '0;
        end
    end

    sdc_emit #(.AW(AW), .MAXN(MAXN), .MW(MW)) u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (vld[M-1]),
        .lanes_log2 (mode_q),
        .tail_flat  (tail_flat),
        .out_valid  (out_valid),
        .out_lane   (out_lane),
        .out_data   (out_data),
        .done       (emit_done)
    );

    always_comb busy = busy_q;

endmodule

// File: rtl/sdc_chain_chk.sv
// Protocol checks for the segmentable chain, attached by bind.
// Observes the output stream, the busy flag and the held configuration.
module sdc_chain_chk #(
    parameter int unsigned AW   = 32,
    parameter int unsigned MAXN = 8,
    parameter int unsigned MW   = 2,
    localparam int unsigned LW  = $clog2(MAXN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            out_valid,
    input logic [LW-1:0]   out_lane,
    input logic [AW-1:0]   out_data,
    input logic [MW-1:0]   mode_q,
    input logic [MAXN-1:0] gate_q
);

    logic [LW:0] n_lanes;

    // Lane count of the held mode.
    always_comb n_lanes = (LW+1)'(1) << mode_q;

    // R8
    valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    // R3
    first_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_lane == '0);

    // R3
    lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_lane == $past(out_lane) + LW'(1));

    // R3
    lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> {1'b0, out_lane} < n_lanes);

    // R5
    gated_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && gate_q[out_lane]) |-> out_data == '0);

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mode_q) && $stable(gate_q)));

endmodule

bind sparse_dot_chain sdc_chain_chk #(.AW(AW), .MAXN(MAXN), .MW(MW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .out_valid (out_valid),
    .out_lane  (out_lane),
    .out_data  (out_data),
    .mode_q    (mode_q),
    .gate_q    (gate_q)
);

// File: tb/sparse_dot_chain_test.sv
// Self-checking bench: seeded random operations in every mode, mixed with
// directed corner cases, compared against a software dot-product model.
module sparse_dot_chain_test;

    localparam int CLK_PERIOD = 10;
    localparam int M  = 16;
    localparam int DW = 8;
    localparam int IW = 4;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_lanes_log2 = '0;
    logic [7:0]      cfg_gate = '0;
    logic            act_we = 1'b0;
    logic [IW-1:0]   act_addr = '0;
    logic [DW-1:0]   act_data = '0;
    logic            op_valid = 1'b0;
    logic [M*DW-1:0] op_w = '0;
    logic [M*IW-1:0] op_idx = '0;
    logic            busy;
    logic            out_valid;
    logic [2:0]      out_lane;
    logic [AW-1:0]   out_data;

    int n_checks = 0;
    int n_fails  = 0;

    logic signed [DW-1:0] act_m [M];
    int   mode_m = 0;
    logic [7:0] gate_m = '0;
    int   dist_addr = 0;
    logic [DW-1:0] dist_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sparse_dot_chain uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_lanes_log2(cfg_lanes_log2), .cfg_gate(cfg_gate),
        .act_we(act_we), .act_addr(act_addr), .act_data(act_data),
        .op_valid(op_valid), .op_w(op_w), .op_idx(op_idx),
        .busy(busy), .out_valid(out_valid), .out_lane(out_lane), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint actual, input longint expected);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
        end
    endtask

    // Model of one lane result from the requirements (R1, R2, R5).
    function automatic longint model_lane(input int c, input int lg, input logic [7:0] gate,
                                          input logic [M*DW-1:0] w, input logic [M*IW-1:0] idx);
        int len = M >> lg;
        longint sum = 0;
        if (gate[c]) return 0;
        for (int j = 0; j < len; j++) begin
            int s = c * len + j;
            longint xv;
            if (lg == 0) xv = act_m[s];
            else         xv = act_m[idx[s*IW +: IW]];
            sum += xv * longint'($signed(w[s*DW +: DW]));
        end
        return sum;
    endfunction

    task automatic write_act(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        act_we = 1'b1; act_addr = IW'(a); act_data = d;
        @(negedge clk);
        act_we = 1'b0;
        act_m[a] = d;
    endtask

    task automatic set_cfg(input int lg, input logic [7:0] gate);
        @(negedge clk);
        cfg_we = 1'b1; cfg_lanes_log2 = 2'(lg); cfg_gate = gate;
        @(negedge clk);
        cfg_we = 1'b0;
        mode_m = lg; gate_m = gate;
    endtask

    // Run one operation and compare every beat; optionally disturb while busy.
    task automatic do_op(input string tag, input bit disturb,
                         input logic [M*DW-1:0] w, input logic [M*IW-1:0] idx);
        longint exp_v [8];
        int n = 1 << mode_m;
        int len = M >> mode_m;
        int t, beats, first_t, last_t;
        bit seq_ok = 1'b1;
        for (int c = 0; c < n; c++) exp_v[c] = model_lane(c, mode_m, gate_m, w, idx);
        @(negedge clk);
        op_valid = 1'b1; op_w = w; op_idx = idx;
        @(negedge clk);
        op_valid = 1'b0;
        t = 1; beats = 0; first_t = -1; last_t = -1;
        check(busy == 1'b1, "R8", "busy after accept", longint'(busy), 1);
        if (disturb) begin
            cfg_we = 1'b1; cfg_lanes_log2 = ~2'(mode_m); cfg_gate = ~gate_m;
            op_valid = 1'b1; op_w = ~w; op_idx = ~idx;
            dist_addr = int'($urandom % M); dist_data = DW'($urandom);
            act_we = 1'b1; act_addr = IW'(dist_addr); act_data = dist_data;
        end
        while (t < 80) begin
            if (out_valid) begin
                if (first_t < 0) first_t = t;
                if (last_t >= 0 && last_t != t - 1) seq_ok = 1'b0;
                last_t = t;
                check(int'(out_lane) == beats, tag, "lane order", out_lane, beats);
                if (beats < n)
                    check($signed(out_data) == exp_v[beats], tag, "lane result",
                          longint'($signed(out_data)), exp_v[beats]);
                beats++;
            end
            if (!busy && t > 1) break;
            @(negedge clk);
            if (disturb && t == 1) begin
                cfg_we = 1'b0; op_valid = 1'b0; act_we = 1'b0;
                act_m[dist_addr] = dist_data;
            end
            t++;
        end
        check(beats == n, tag, "beat count", beats, n);
        check(seq_ok, "R3", "beats consecutive", seq_ok, 1);
        check(first_t == len + 2, "R4", "first beat cycle", first_t, len + 2);
        check(!busy && !out_valid, "R8", "idle after last beat", busy, 0);
    endtask

    function automatic logic [M*DW-1:0] rand_w();
        logic [M*DW-1:0] v;
        for (int i = 0; i < M; i++) v[i*DW +: DW] = DW'($urandom);
        return v;
    endfunction

    function automatic logic [M*IW-1:0] rand_idx();
        logic [M*IW-1:0] v;
        for (int i = 0; i < M; i++) v[i*IW +: IW] = IW'($urandom);
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [M*DW-1:0] w;
        logic [M*IW-1:0] idx;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < M; i++) act_m[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(busy == 1'b0, "R8", "busy at reset", busy, 0);
        check(out_valid == 1'b0, "R8", "out_valid at reset", out_valid, 0);

        // R8: reset activations are zero, dense mode, no gating
        w = rand_w();
        do_op("R8", 1'b0, w, '0);

        for (int i = 0; i < M; i++) write_act(i, DW'($urandom));

        // R1: dense dot product, indices must not matter
        do_op("R1", 1'b0, rand_w(), rand_idx());
        do_op("R1", 1'b0, rand_w(), '1);

        // R2: each sparse mode with random indices
        for (int lg = 1; lg <= 3; lg++) begin
            set_cfg(lg, 8'h00);
            do_op("R2", 1'b0, rand_w(), rand_idx());
        end

        // R9: full-scale negative operands, dense and eight lanes
        for (int i = 0; i < M; i++) write_act(i, 8'h80);
        set_cfg(0, 8'h00);
        w = {M{8'h80}};
        do_op("R9", 1'b0, w, '0);
        set_cfg(3, 8'h00);
        do_op("R9", 1'b0, w, rand_idx());

        // R5: all lanes gated, then alternate lanes, then gate bits beyond N
        for (int i = 0; i < M; i++) write_act(i, DW'($urandom));
        set_cfg(3, 8'hFF);
        do_op("R5", 1'b0, rand_w(), rand_idx());
        set_cfg(2, 8'h05);
        do_op("R5", 1'b0, rand_w(), rand_idx());
        set_cfg(1, 8'hFC);
        do_op("R5", 1'b0, rand_w(), rand_idx());
        set_cfg(0, 8'hFE);
        do_op("R5", 1'b0, rand_w(), rand_idx());

        // R6: configuration and operation offered while busy are ignored
        set_cfg(1, 8'h00);
        do_op("R6", 1'b1, rand_w(), rand_idx());
        w = '0;
        for (int i = 0; i < M; i++) w[i*DW +: DW] = 8'd1;
        do_op("R6", 1'b0, rand_w(), rand_idx());

        // R7: the activation written while busy feeds the next operation
        set_cfg(2, 8'h00);
        do_op("R7", 1'b1, rand_w(), rand_idx());
        idx = {M{IW'(dist_addr)}};
        do_op("R7", 1'b0, w, idx);

        // Random operations across modes, gates and disturbances (R2, R3)
        for (int k = 0; k < 60; k++) begin
            int lg = int'($urandom % 4);
            logic [7:0] g = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            if ($urandom % 5 == 0) write_act(int'($urandom % M), DW'($urandom));
            set_cfg(lg, g);
            do_op((lg == 0) ? "R1" : "R2", ($urandom % 3 == 0), rand_w(), rand_idx());
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule